// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the bus-side sequencer of a 2 KiB serial EEPROM. A fast system clock oversamples the two-wire clock and data lines. The block recognises start and stop conditions and shifts bytes in and out, most significant bit first. It answers each byte with an acknowledge by pulling the data line low through an active-high output-enable, because the line itself is open-drain.

A transaction opens with a select byte. Its upper nibble must equal `1010`. Its next three bits choose one of eight 256-byte blocks, and these bits become the top of the 11-bit memory address. Its last bit chooses the direction. On a write, a one-byte word address follows, and then any number of data bytes. On a read, bytes are streamed out from whatever location the external pointer holds.

The block does not own the memory array, the page buffer, the address pointer or the write timer. It talks to them through single-cycle strobes, and it reads the byte at the pointer through a plain data input. A write-protect input and a busy input from the write timer gate which bytes are acknowledged.

Top module: `eeprom_i2c_ctrl`

## Requirements
- R1: A start condition (SDA falling while SCL is high) at any point restarts select-byte decoding. It also discards any accepted write data, so a later stop does not pulse `wr_commit_o`.
- R2: A select byte whose upper four bits are `1010` is acknowledged by driving `sda_oe_o` high during the ninth clock. Any other select byte is not acknowledged, and every later byte is ignored (no acknowledge, no strobe) until the next start.
- R3: On a write (select bit 0 = 0), the next byte is acknowledged, and one `adr_set_o` pulse follows. At that pulse, `adr_o[10:8]` holds select bits 3..1 and `adr_o[7:0]` holds the received byte.
- R4: With `wp_i` low, each data byte after the word address is acknowledged, and one `wr_stb_o` pulse follows with the byte (first bit received in bit 7) on `wr_data_o`.
- R5: With `wp_i` high, the select byte and the word address are still acknowledged. Data bytes are not acknowledged, and they produce no `wr_stb_o` and no `wr_commit_o`.
- R6: While `busy_i` is high, a matching select byte is not acknowledged, and no strobe follows.
- R7: A stop condition (SDA rising while SCL is high) pulses `wr_commit_o` once if at least one data byte was accepted since the last start. Otherwise it does not pulse.
- R8: On a read (select bit 0 = 1), the block drives `rd_data_i` out MSB first, starting at the pointer's current value with no address phase. It pulses `rd_adv_o` once per byte sent, and it keeps sending while the master acknowledges.
- R9: During the master's acknowledge clock the data line is released. After a master not-acknowledge, the block drives nothing until the next start.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: After reset, `sda_oe_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write protect, high blocks data bytes |
| busy_i | input | 1 | High while the internal write cycle runs |
| rd_data_i | input | 8 | Byte at the external address pointer |
| sda_oe_o | output | 1 | High pulls the data line low |
| adr_set_o | output | 1 | Pulse: load the pointer with `adr_o` |
| adr_o | output | 11 | Address to load into the pointer |
| wr_stb_o | output | 1 | Pulse: push `wr_data_o` into the page buffer |
| wr_data_o | output | 8 | Received data byte |
| rd_adv_o | output | 1 | Pulse: a read byte went out, advance the pointer |
| wr_commit_o | output | 1 | Pulse: start the internal write cycle |

## Verification
The bus inputs pass through a synchroniser of `SYNC_STAGES` flops, and one more register cycle follows. Each decision therefore shows a few system cycles after the SCL edge that caused it. Acknowledges and read bits appear that long after SCL falls, and the bench holds SCL low for ten cycles before sampling on the following high phase. Strobes come a few cycles after the eighth falling edge of a byte or after a stop. The driver queues each expected strobe before it sends the byte. A monitor pops the queue on every strobe, and at the end the bench requires the queue to be empty, so a missing or extra strobe is caught as well as a wrong value.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_WADR,
        PH_WDAT,
        PH_RD
    } phase_e;
endpackage

// File: rtl/eeprom_i2c_sync.sv
module eeprom_i2c_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES-1:0] scl_ff_q, sda_ff_q;
    logic                   scl_p_q, sda_p_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff_q[i] <= 1'b1;
                    sda_ff_q[i] <= 1'b1;
                end else if (i == 0) begin
                    scl_ff_q[i] <= scl_i;
                    sda_ff_q[i] <= sda_i;
                end else begin
                    scl_ff_q[i] <= scl_ff_q[(i == 0) ? 0 : i-1];
                    sda_ff_q[i] <= sda_ff_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s_o;
            sda_p_q <= sda_s_o;
        end
    end

    assign scl_s_o    = scl_ff_q[SYNC_STAGES-1];
    assign sda_s_o    = sda_ff_q[SYNC_STAGES-1];
    assign scl_rise_o = scl_s_o & ~scl_p_q;
    assign scl_fall_o = ~scl_s_o & scl_p_q;
    assign start_o    = scl_s_o & scl_p_q & sda_p_q & ~sda_s_o;
    assign stop_o     = scl_s_o & scl_p_q & ~sda_p_q & sda_s_o;
endmodule

// File: rtl/eeprom_i2c_fsm.sv
module eeprom_i2c_fsm
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s_i,
    input  logic                sda_s_i,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                wp_i,
    input  logic                busy_i,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic                sda_oe_o,
    output logic                adr_set_o,
    output logic [ADDR_W-1:0]   adr_o,
    output logic                wr_stb_o,
    output logic [BYTE_W-1:0]   wr_data_o,
    output logic                rd_adv_o,
    output logic                wr_commit_o
);
    localparam int BLK_W = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_e              ph;
        phase_e              nxt;
        logic                ackph;
        logic [CNT_W-1:0]    bcnt;
        logic [BYTE_W-1:0]   sh;
        logic [BLK_W-1:0]    blk;
        logic [ADDR_W-1:0]   adr;
        logic                mack;
        logic                wrote;
        logic                oe;
        logic                adr_set;
        logic                wdat_stb;
        logic                rdat_adv;
        logic                commit;
    } ctl_t;

    ctl_t d, q;

    always_comb begin
        d          = q;
        d.adr_set  = 1'b0;
        d.wdat_stb = 1'b0;
        d.rdat_adv = 1'b0;
        d.commit   = 1'b0;
        if (start_i) begin
            d.ph = PH_DEV; d.ackph = 1'b0; d.bcnt = '0; d.oe = 1'b0; d.wrote = 1'b0;
        end else if (stop_i) begin
            d.commit = q.wrote; d.wrote = 1'b0;
            d.ph = PH_IDLE; d.ackph = 1'b0; d.bcnt = '0; d.oe = 1'b0;
        end else if (q.ph == PH_RD) begin
            if (scl_rise_i && q.ackph) d.mack = ~sda_s_i;
            if (scl_fall_i) begin
                if (!q.ackph) begin
                    if (q.bcnt == LAST_BIT) begin
                        d.oe = 1'b0; d.ackph = 1'b1; d.rdat_adv = 1'b1;
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                        d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe   = ~q.sh[BYTE_W-2];
                    end
                end else if (q.mack) begin
                    d.sh = rd_data_i; d.oe = ~rd_data_i[BYTE_W-1];
                    d.bcnt = '0; d.ackph = 1'b0;
                end else begin
                    d.ph = PH_IDLE; d.ackph = 1'b0; d.oe = 1'b0;
                end
            end
        end else if (q.ph != PH_IDLE) begin
            if (scl_rise_i && !q.ackph && q.bcnt != FULL) begin
                d.sh   = {q.sh[BYTE_W-2:0], sda_s_i};
                d.bcnt = q.bcnt + 1'b1;
            end
            if (scl_fall_i) begin
                if (!q.ackph && q.bcnt == FULL) begin
                    d.ackph = 1'b1;
                    d.nxt   = PH_IDLE;
                    case (q.ph)
                        PH_DEV: begin
                            if (q.sh[BYTE_W-1:BYTE_W-4] == DEV_CODE && !busy_i) begin
                                d.oe  = 1'b1;
                                d.blk = q.sh[BLK_W:1];
                                d.nxt = q.sh[0] ? PH_RD : PH_WADR;
                            end
                        end
                        PH_WADR: begin
                            d.oe = 1'b1; d.adr_set = 1'b1;
                            d.adr = {q.blk, q.sh};
                            d.nxt = PH_WDAT;
                        end
                        PH_WDAT: begin
                            d.nxt = PH_WDAT;
                            if (!wp_i) begin
                                d.oe = 1'b1; d.wdat_stb = 1'b1; d.wrote = 1'b1;
                            end
                        end
                        default: d.nxt = PH_IDLE;
                    endcase
                end else if (q.ackph) begin
                    d.ackph = 1'b0; d.bcnt = '0; d.oe = 1'b0; d.ph = q.nxt;
                    if (q.nxt == PH_RD) begin
                        d.sh = rd_data_i; d.oe = ~rd_data_i[BYTE_W-1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, nxt: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign adr_set_o   = q.adr_set;
    assign adr_o       = q.adr;
    assign wr_stb_o    = q.wdat_stb;
    assign wr_data_o   = q.sh;
    assign rd_adv_o    = q.rdat_adv;
    assign wr_commit_o = q.commit;

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !$past(scl_s_i));
    // R5
    wp_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wdat_stb |-> !$past(wp_i));
    // R7
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> $past(stop_i));
    // R9
    master_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdat_adv |-> !q.oe);
    // R3
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.adr_set, q.wdat_stb, q.rdat_adv, q.commit}));
endmodule

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic              adr_set_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic              wr_stb_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_adv_o,
    output logic              wr_commit_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    eeprom_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    eeprom_i2c_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s_i     (scl_s),
        .sda_s_i     (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_evt),
        .stop_i      (stop_evt),
        .wp_i        (wp_i),
        .busy_i      (busy_i),
        .rd_data_i   (rd_data_i),
        .sda_oe_o    (sda_oe_o),
        .adr_set_o   (adr_set_o),
        .adr_o       (adr_o),
        .wr_stb_o    (wr_stb_o),
        .wr_data_o   (wr_data_o),
        .rd_adv_o    (rd_adv_o),
        .wr_commit_o (wr_commit_o)
    );
endmodule

// File: tb/eeprom_i2c_ctrl_tb.sv
module eeprom_i2c_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        wp = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  rd_data;
    logic        sda_oe, adr_set, wr_stb, rd_adv, wr_commit;
    logic [10:0] adr;
    logic [7:0]  wr_data;
    logic        sda_bus;
    logic [10:0] env_ptr = '0;
    int          checks = 0;
    int          fails = 0;
    int          oe_bad = 0;
    bit          done = 0;

    typedef struct { int kind; int val; } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] pat(input logic [10:0] a);
        return a[7:0] ^ {5'b0, a[10:8]} ^ 8'h5A;
    endfunction

    assign rd_data = pat(env_ptr);

    always @(posedge clk) begin
        if (adr_set) env_ptr <= adr;
        else if (rd_adv) env_ptr <= env_ptr + 11'd1;
    end

    eeprom_i2c_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wp_i(wp),
        .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
        .adr_set_o(adr_set), .adr_o(adr), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
        .rd_adv_o(rd_adv), .wr_commit_o(wr_commit)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input int kind, input int val);
        item_t it;
        it.kind = kind; it.val = val;
        exp_q.push_back(it);
    endtask

    // Monitor: pops the scoreboard on each strobe; also watches R10 at the pins.
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== oe_prev && scl) oe_bad++;
            oe_prev = sda_oe;
            if (adr_set || wr_stb || rd_adv || wr_commit) begin
                int k, v;
                item_t it;
                k = adr_set ? 0 : wr_stb ? 1 : rd_adv ? 2 : 3;
                v = adr_set ? int'(adr) : wr_stb ? int'(wr_data) : 0;
                if (exp_q.size() == 0) begin
                    chk("R3/R4/R5/R7 unexpected strobe kind", k, -1);
                end else begin
                    it = exp_q.pop_front();
                    chk("R3/R4/R8/R7 strobe kind", k, it.kind);
                    chk("R3/R4 strobe value", v, it.val);
                end
            end
        end
    end

    task automatic bit_x(input logic b, output logic smp);
        sda_m = b;
        repeat (10) @(negedge clk);
        scl = 1'b1;
        repeat (10) @(negedge clk);
        smp = sda_bus;
        scl = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; repeat (10) @(negedge clk);
        scl = 1'b1;   repeat (10) @(negedge clk);
        sda_m = 1'b0; repeat (10) @(negedge clk);
        scl = 1'b0;   repeat (10) @(negedge clk);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; repeat (10) @(negedge clk);
        scl = 1'b1;   repeat (10) @(negedge clk);
        sda_m = 1'b1; repeat (20) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, s);
            b[i] = s;
        end
        bit_x(~mack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        chk("R11 reset sda_oe", sda_oe, 0);
        chk("R11 reset strobes", {adr_set, wr_stb, rd_adv, wr_commit}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Write two bytes into block 3
        do_start();
        send(8'hA6, a); chk("R2 select ack", a, 1);
        push(0, 11'h31E);
        send(8'h1E, a); chk("R3 word address ack", a, 1);
        push(1, 8'hA5);
        send(8'hA5, a); chk("R4 data ack", a, 1);
        push(1, 8'h3C);
        send(8'h3C, a); chk("R4 data ack 2", a, 1);
        push(3, 0);
        do_stop();

        // Wrong device code, then a further byte is ignored
        do_start();
        send(8'h90, a); chk("R2 mismatch nack", a, 0);
        send(8'hA0, a); chk("R2 ignored until start", a, 0);
        do_stop();

        // Busy write cycle
        busy = 1'b1;
        do_start();
        send(8'hA0, a); chk("R6 busy nack", a, 0);
        do_stop();
        busy = 1'b0;

        // Write protect
        wp = 1'b1;
        do_start();
        send(8'hA4, a); chk("R5 select ack under wp", a, 1);
        push(0, 11'h240);
        send(8'h40, a); chk("R5 word ack under wp", a, 1);
        send(8'h77, a); chk("R5 data nack under wp", a, 0);
        do_stop();
        wp = 1'b0;

        // Random read across a block boundary
        do_start();
        send(8'hA2, a); chk("R2 select ack", a, 1);
        push(0, 11'h1FE);
        send(8'hFE, a); chk("R3 word ack", a, 1);
        do_start();
        send(8'hA3, a); chk("R1 repeated start read select ack", a, 1);
        push(2, 0); recv(1'b1, rb); chk("R8 read byte 0", rb, pat(11'h1FE));
        push(2, 0); recv(1'b1, rb); chk("R8 read byte 1", rb, pat(11'h1FF));
        push(2, 0); recv(1'b0, rb); chk("R8 read byte 2", rb, pat(11'h200));
        bit_x(1'b1, a); chk("R9 released after master nack", a, 1);
        do_stop();

        // Current-address read
        do_start();
        send(8'hA1, a); chk("R8 current read select ack", a, 1);
        push(2, 0); recv(1'b0, rb); chk("R8 current address byte", rb, pat(11'h201));
        do_stop();

        // Repeated start discards accepted data
        do_start();
        send(8'hA0, a); chk("R2 select ack", a, 1);
        push(0, 11'h010);
        send(8'h10, a); chk("R3 word ack", a, 1);
        push(1, 8'h55);
        send(8'h55, a); chk("R4 data ack", a, 1);
        do_start();
        send(8'h90, a); chk("R1 select after repeated start", a, 0);
        do_stop();

        // Address only, no data: no commit
        do_start();
        send(8'hA0, a); chk("R2 select ack", a, 1);
        push(0, 11'h020);
        send(8'h20, a); chk("R3 word ack", a, 1);
        do_stop();

        repeat (20) @(negedge clk);
        chk("R7 no missing strobes", exp_q.size(), 0);
        chk("R10 sda_oe stable while scl high", oe_bad, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule